// File: doc/BRIEF.md
# Thermal Throttling Escalation Controller

This block sequences the thermal response of one core. When the core-hot input is raised, it first lowers the requested operating point. Operating point index 0 is the nominal, fastest point and index NUM_OPP-1 is the slowest. If the core is still hot after a programmable escalation time, the block adds periodic clock stopping through a clock-enable gate. When the hot input drops, the block lifts the gating at once. It then walks the operating point back up to nominal, one step per dwell interval.

Software reaches the block through a small word-addressed register port. The control word holds the gating enable, the mode bit, the stop duty in eighths and the interrupt enables. The dwell count and the escalation timeout each have their own word. A fourth word holds the sticky event bits, which are cleared by writing ones. Sequencing of the clock generator and voltage regulator happens outside the block, and so does temperature sensing.

Top module: `thermal_escalator`

## Requirements
- R1: After reset, `opp_o` is 0, `clk_en_o` is 1, `irq_o` is 0, and the control and status words read back as 0.
- R2: With control bit 1 (adaptive) clear, a hot input sampled while the operating point is above the slowest point sets `opp_o` to NUM_OPP-1 one cycle later. While the input is hot, `opp_o` never decreases.
- R3: With control bit 1 set, the first hot sample at nominal gives `opp_o` = 1 one cycle later. Each further step down follows after dwell+1 cycles of continuous hot. Stepping stops at NUM_OPP-1.
- R4: In adaptive mode, once hot clears, no further downward step occurs. The block stays at the point it reached until restoration begins.
- R5: Clock gating begins only after hot has been sampled continuously for timeout+1 cycles. `clk_en_o` stays 1 for exactly timeout+1 cycles after hot rises and then drops.
- R6: While gating is active, `clk_en_o` is 0 in exactly N of every 8 consecutive cycles. N is control bits [4:2].
- R7: If control bit 0 (gating enable) is clear, or N is 0, `clk_en_o` stays 1 even after the escalation time has passed.
- R8: When hot drops, `clk_en_o` returns to 1 within 2 cycles. `opp_o` then rises one step at a time. The first step comes dwell+2 cycles after the first cold sample and later steps come dwell+1 cycles apart, until `opp_o` reaches 0.
- R9: Status word (address 3) sticky bits: bit 0 is hot onset, bit 1 is gating engaged, bit 2 is back at nominal. Writing 1 clears a bit, writing 0 has no effect, and a new event in the same cycle as a clear leaves the bit set.
- R10: `irq_o` is the registered OR of the status bits that are set and enabled by control bits [10:8]. With all enables clear it stays 0.
- R11: Registers are read one cycle after the address is presented. Address 0 is control, 1 is dwell (DWELL_W bits), 2 is timeout (TMO_W bits) and 3 is status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hot_i | input | 1 | Core-hot condition, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for `reg_addr` |
| opp_o | output | $clog2(NUM_OPP) | Requested operating point index, 0 is nominal |
| clk_en_o | output | 1 | Core clock-enable gate |
| irq_o | output | 1 | Thermal event interrupt |

## Verification
Two functions can land in the same cycle: a software clear of a status bit, and the hardware event that sets that same bit. The bench clears the hot-onset bit, raises hot, and times a write-one-to-clear of that bit so it reaches the status register on the very edge where the onset event is recorded. Reading the bit back as 1 shows that the event took priority over the clear. A second, later clear with no event pending must then return the bit to 0.

// File: rtl/therm_pkg.sv
package therm_pkg;
  localparam int ADDR_W        = 2;
  localparam int REG_CTRL      = 0;
  localparam int REG_DWELL     = 1;
  localparam int REG_TMO       = 2;
  localparam int REG_STAT      = 3;

  localparam int CTRL_GATE_EN  = 0;
  localparam int CTRL_ADAPT    = 1;
  localparam int CTRL_DUTY_LSB = 2;
  localparam int CTRL_IE_LSB   = 8;
  localparam int DUTY_W        = 3;

  localparam int NUM_EV        = 3;
  localparam int EV_HOT        = 0;
  localparam int EV_ESC        = 1;
  localparam int EV_NOM        = 2;

  typedef struct packed {
    logic              gate_en;
    logic              adaptive;
    logic [DUTY_W-1:0] duty;
    logic [NUM_EV-1:0] ie;
  } ctrl_t;
endpackage

// File: rtl/therm_regs.sv
module therm_regs
  import therm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DWELL_W = 16,
  parameter int TMO_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_EV-1:0]    ev_i,
  output ctrl_t                ctrl_o,
  output logic [DWELL_W-1:0]   dwell_o,
  output logic [TMO_W-1:0]     tmo_o,
  output logic                 irq_o
);
  ctrl_t               ctrl_q;
  logic [DWELL_W-1:0]  dwell_q;
  logic [TMO_W-1:0]    tmo_q;
  logic [NUM_EV-1:0]   stat_q;
  logic [NUM_EV-1:0]   clr;
  logic [DATA_W-1:0]   rd_mux;
  logic [DATA_W-1:0]   rdata_q;
  logic                irq_q;
  logic                unused_wbits;

  assign unused_wbits = ^wdata_i;
  assign clr = (we_i && addr_i == ADDR_W'(REG_STAT)) ? wdata_i[NUM_EV-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      dwell_q <= '0;
      tmo_q   <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_W'(REG_CTRL): begin
          ctrl_q.gate_en  <= wdata_i[CTRL_GATE_EN];
          ctrl_q.adaptive <= wdata_i[CTRL_ADAPT];
          ctrl_q.duty     <= wdata_i[CTRL_DUTY_LSB +: DUTY_W];
          ctrl_q.ie       <= wdata_i[CTRL_IE_LSB +: NUM_EV];
        end
        ADDR_W'(REG_DWELL): dwell_q <= wdata_i[DWELL_W-1:0];
        ADDR_W'(REG_TMO):   tmo_q   <= wdata_i[TMO_W-1:0];
        default: ;
      endcase
    end
  end

  // one sticky bit per event; the hardware event wins over a clear
  for (genvar i = 0; i < NUM_EV; i++) begin : g_stat
    always_ff @(posedge clk) begin
      if (rst) stat_q[i] <= 1'b0;
      else     stat_q[i] <= ev_i[i] | (stat_q[i] & ~clr[i]);
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_W'(REG_CTRL): begin
        rd_mux[CTRL_GATE_EN]               = ctrl_q.gate_en;
        rd_mux[CTRL_ADAPT]                 = ctrl_q.adaptive;
        rd_mux[CTRL_DUTY_LSB +: DUTY_W]    = ctrl_q.duty;
        rd_mux[CTRL_IE_LSB +: NUM_EV]      = ctrl_q.ie;
      end
      ADDR_W'(REG_DWELL): rd_mux[DWELL_W-1:0] = dwell_q;
      ADDR_W'(REG_TMO):   rd_mux[TMO_W-1:0]   = tmo_q;
      default:            rd_mux[NUM_EV-1:0]  = stat_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_mux;
      irq_q   <= |(stat_q & ctrl_q.ie);
    end
  end

  assign ctrl_o  = ctrl_q;
  assign dwell_o = dwell_q;
  assign tmo_o   = tmo_q;
  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ev_i[EV_HOT] |=> stat_q[EV_HOT]);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q[EV_ESC] && !clr[EV_ESC]) |=> stat_q[EV_ESC]);

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.ie == '0) |=> !irq_q);
endmodule

// File: rtl/therm_opp_seq.sv
module therm_opp_seq
  import therm_pkg::*;
#(
  parameter int NUM_OPP = 8,
  parameter int DWELL_W = 16,
  parameter int TMO_W   = 16,
  localparam int OPP_W  = $clog2(NUM_OPP)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hot_i,
  input  logic                adaptive_i,
  input  logic [DWELL_W-1:0]  dwell_i,
  input  logic [TMO_W-1:0]    tmo_i,
  output logic [OPP_W-1:0]    opp_o,
  output logic                esc_o,
  output logic [NUM_EV-1:0]   ev_o
);
  localparam logic [OPP_W-1:0] LOWEST = OPP_W'(NUM_OPP - 1);
  localparam logic [OPP_W-1:0] NOMINAL = '0;

  logic               hot_q;
  logic [OPP_W-1:0]   opp_q, opp_d;
  logic [DWELL_W-1:0] dcnt_q;
  logic [TMO_W-1:0]   ecnt_q;
  logic               esc_q;
  logic [NUM_EV-1:0]  ev_q;
  logic               changed, hit, esc_start, dcnt_clr;

  assign changed   = hot_i ^ hot_q;
  assign hit       = !changed && (dcnt_q == dwell_i);
  assign esc_start = hot_i && !esc_q && (ecnt_q >= tmo_i);
  assign dcnt_clr  = changed || hit || (hot_i && opp_q == NOMINAL);

  always_comb begin
    opp_d = opp_q;
    if (hot_i) begin
      if (!adaptive_i)                      opp_d = LOWEST;
      else if (opp_q == NOMINAL)            opp_d = OPP_W'(1);
      else if (hit && opp_q != LOWEST)      opp_d = opp_q + OPP_W'(1);
    end else if (hit && opp_q != NOMINAL) begin
      opp_d = opp_q - OPP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hot_q  <= 1'b0;
      opp_q  <= NOMINAL;
      dcnt_q <= '0;
    end else begin
      hot_q  <= hot_i;
      opp_q  <= opp_d;
      dcnt_q <= dcnt_clr ? '0 : dcnt_q + DWELL_W'(1);
    end
  end

  // escalation timer: runs while hot, arms the secondary tier
  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt_q <= '0;
      esc_q  <= 1'b0;
    end else if (!hot_i) begin
      ecnt_q <= '0;
      esc_q  <= 1'b0;
    end else begin
      if (ecnt_q < tmo_i) ecnt_q <= ecnt_q + TMO_W'(1);
      if (esc_start)      esc_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ev_q <= '0;
    else begin
      ev_q[EV_HOT] <= hot_i && !hot_q;
      ev_q[EV_ESC] <= esc_start;
      ev_q[EV_NOM] <= !hot_i && opp_q == OPP_W'(1) && opp_d == NOMINAL;
    end
  end

  assign opp_o = opp_q;
  assign esc_o = esc_q;
  assign ev_o  = ev_q;

  // R2
  hot_no_raise_chk: assert property (@(posedge clk) disable iff (rst)
    hot_i |=> (opp_q >= $past(opp_q)));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hot_i && adaptive_i && $past(opp_q) != NOMINAL) |=>
      (opp_q == $past(opp_q) || opp_q == $past(opp_q) + OPP_W'(1)));

  // R8
  cold_no_esc_chk: assert property (@(posedge clk) disable iff (rst)
    !hot_i |=> !esc_q);

  // R8
  cold_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !hot_i |=> (opp_q <= $past(opp_q)));
endmodule

// File: rtl/therm_clk_mod.sv
module therm_clk_mod
  import therm_pkg::*;
#(
  parameter int SLOT_W = DUTY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_i,
  input  logic              gate_en_i,
  input  logic [SLOT_W-1:0] duty_i,
  output logic              gate_o
);
  logic [SLOT_W-1:0] slot_q;
  logic              gate_q;
  logic              stop_now;

  assign stop_now = act_i && gate_en_i && (duty_i != '0) && (slot_q < duty_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      gate_q <= 1'b1;
    end else begin
      slot_q <= act_i ? slot_q + SLOT_W'(1) : '0;
      gate_q <= !stop_now;
    end
  end

  assign gate_o = gate_q;

  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!gate_en_i || duty_i == '0) |=> gate_q);

  // R5
  stop_needs_act_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_q |-> $past(act_i));
endmodule

// File: rtl/thermal_escalator.sv
module thermal_escalator
  import therm_pkg::*;
#(
  parameter int NUM_OPP = 8,
  parameter int DATA_W  = 32,
  parameter int DWELL_W = 16,
  parameter int TMO_W   = 16,
  localparam int OPP_W  = $clog2(NUM_OPP)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hot_i,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [OPP_W-1:0]   opp_o,
  output logic               clk_en_o,
  output logic               irq_o
);
  ctrl_t              ctrl;
  logic [DWELL_W-1:0] dwell;
  logic [TMO_W-1:0]   tmo;
  logic [NUM_EV-1:0]  ev;
  logic               esc;

  therm_regs #(.DATA_W(DATA_W), .DWELL_W(DWELL_W), .TMO_W(TMO_W)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .we_i    (reg_we),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .rdata_o (reg_rdata),
    .ev_i    (ev),
    .ctrl_o  (ctrl),
    .dwell_o (dwell),
    .tmo_o   (tmo),
    .irq_o   (irq_o)
  );

  therm_opp_seq #(.NUM_OPP(NUM_OPP), .DWELL_W(DWELL_W), .TMO_W(TMO_W)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .hot_i      (hot_i),
    .adaptive_i (ctrl.adaptive),
    .dwell_i    (dwell),
    .tmo_i      (tmo),
    .opp_o      (opp_o),
    .esc_o      (esc),
    .ev_o       (ev)
  );

  therm_clk_mod #(.SLOT_W(DUTY_W)) mod_i (
    .clk       (clk),
    .rst       (rst),
    .act_i     (esc),
    .gate_en_i (ctrl.gate_en),
    .duty_i    (ctrl.duty),
    .gate_o    (clk_en_o)
  );
endmodule

// File: tb/thermal_escalator_tb_top.sv
module thermal_escalator_tb_top;
  localparam int NOPP = 8;
  localparam int DW   = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hot = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [2:0]    opp;
  logic          clk_en, irq;

  int checks = 0;
  int errors = 0;

  thermal_escalator #(.NUM_OPP(NOPP), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .hot_i(hot), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .opp_o(opp), .clk_en_o(clk_en),
    .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  // {gate_en, duty, expected stopped cycles in 64}
  localparam logic [10:0] VEC [0:9] = '{
    {1'b1, 3'd0, 7'd0},  {1'b1, 3'd1, 7'd8},  {1'b1, 3'd2, 7'd16},
    {1'b1, 3'd3, 7'd24}, {1'b1, 3'd4, 7'd32}, {1'b1, 3'd5, 7'd40},
    {1'b1, 3'd6, 7'd48}, {1'b1, 3'd7, 7'd56}, {1'b0, 3'd5, 7'd0},
    {1'b0, 3'd7, 7'd0}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1'b1; addr = 2'(a); wdata = DW'(d);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); addr = 2'(a);
    @(negedge clk); d = int'(rdata);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, n, lows, mx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 opp", opp, 0);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 irq", irq, 0);
    rd(3, v); chk("R1 status", v, 0);
    rd(0, v); chk("R1 ctrl", v, 0);

    // R11 readback
    wr(1, 32'h0001_1234); rd(1, v); chk("R11 dwell", v, 32'h1234);
    wr(2, 32'h0000_BEEF); rd(2, v); chk("R11 timeout", v, 32'hBEEF);
    wr(0, 32'h0000_0716); rd(0, v); chk("R11 ctrl", v, 32'h0716);

    // table: duty setting vs stopped cycles (R6, R7), LFM jump (R2), release (R8)
    wr(1, 1); wr(2, 3);
    for (int r = 0; r < 10; r++) begin
      wr(0, int'(VEC[r][10]) | (int'(VEC[r][9:7]) << 2));
      @(negedge clk); hot = 1'b1;
      cycles(10);
      chk("R2 lfm lowest", opp, NOPP - 1);
      lows = 0;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        if (!clk_en) lows++;
      end
      chk(VEC[r][10] && VEC[r][9:7] != 0 ? "R6 duty" : "R7 gate held", lows, VEC[r][6:0]);
      hot = 1'b0;
      cycles(2);
      chk("R8 gate release", clk_en, 1);
      cycles(20);
      chk("R8 restored", opp, 0);
    end

    // R5 escalation delay, R2 exact timing
    wr(2, 20); wr(0, 1 | (4 << 2));
    @(negedge clk); hot = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      if (n == 0) chk("R2 lfm next cycle", opp, NOPP - 1);
      if (!clk_en) break;
      n++;
    end
    chk("R5 high before gating", n, 21);
    hot = 1'b0;
    cycles(20);

    // R3 adaptive stepping
    wr(2, 1000); wr(1, 5); wr(0, 32'h2);
    @(negedge clk); hot = 1'b1;
    @(negedge clk); chk("R3 first step", opp, 1);
    n = 0;
    while (opp == 1) begin @(negedge clk); n++; end
    chk("R3 dwell interval", n, 6);
    chk("R3 second step", opp, 2);
    cycles(60); chk("R3 stops at lowest", opp, NOPP - 1);
    cycles(20); chk("R3 holds lowest", opp, NOPP - 1);
    hot = 1'b0;
    cycles(60); chk("R8 back to nominal", opp, 0);

    // R4 / R8 adaptive release mid-way
    wr(3, 7);
    @(negedge clk); hot = 1'b1;
    while (opp != 2) @(negedge clk);
    hot = 1'b0;
    n = 0; mx = 2;
    while (opp == 2) begin @(negedge clk); n++; if (opp > mx) mx = opp; end
    chk("R4 no further drop", mx, 2);
    chk("R8 first raise delay", n, 7);
    n = 0;
    while (opp == 1) begin @(negedge clk); n++; end
    chk("R8 raise interval", n, 6);
    chk("R8 nominal", opp, 0);
    cycles(2);
    rd(3, v); chk("R9 nominal event", (v >> 2) & 1, 1);

    // R9 clear vs event collision, R10 interrupt
    wr(0, 32'h0702);
    wr(3, 7); rd(3, v); chk("R9 cleared", v, 0);
    cycles(2); chk("R10 irq low", irq, 0);
    @(negedge clk); hot = 1'b1;
    @(negedge clk); we = 1'b1; addr = 2'd3; wdata = 1;
    @(negedge clk); we = 1'b0;
    rd(3, v); chk("R9 event wins over clear", v & 1, 1);
    chk("R10 irq set", irq, 1);
    wr(3, 0); rd(3, v); chk("R9 write zero ignored", v & 1, 1);
    wr(3, 7); rd(3, v); chk("R9 write one clears", v, 0);
    cycles(2); chk("R10 irq drops", irq, 0);
    wr(0, 32'h0002);
    hot = 1'b0;
    cycles(60);
    rd(3, v); chk("R9 nominal again", (v >> 2) & 1, 1);
    chk("R10 masked", irq, 0);
    wr(0, 32'h0402);
    cycles(2); chk("R10 enabled bit", irq, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule